// File: doc/BRIEF.md
# Latched BCD Seven-Segment Decoder

This block turns a four-bit decimal digit into the seven segment drive bits of a numeric display. A holding register captures the digit on the system clock while the hold control is low. It keeps the last captured digit for as long as hold is high. The segment outputs are decoded from the held digit. Two active-low overrides then act on them: a lamp test that lights every segment, and a blank that darkens every segment. Lamp test wins over blank. Neither override touches the held digit, so the digit shows again as soon as both are released.

Codes above nine are not decimal digits and produce a dark display. The digit input is a plain level with no valid/ready handshake. The register samples it whenever hold is low and never pushes back, so the producer needs no back-pressure logic. A single active-low reset, applied asynchronously, clears the held digit to zero.

Top module: `bcd7seg_latch`

## Requirements
- R1: At every rising clock edge where `hold_en` is low, the held digit takes the value of `digit_in`.
- R2: While `hold_en` is high at a rising edge, the held digit keeps its value and changes on `digit_in` do not reach `seg_out`.
- R3: With `lamp_test_n` low, `seg_out` is 7'h7F, whatever the values of `hold_en`, `blank_n` and the held digit.
- R4: With `lamp_test_n` high and `blank_n` low, `seg_out` is 7'h00.
- R5: `lamp_test_n` and `blank_n` never alter the held digit. Once both are high again, `seg_out` shows the digit that was held before.
- R6: A held code from 10 to 15 gives `seg_out` = 7'h00 when no override is active.
- R7: The segment bits map as bit0=a (top), bit1=b (upper right), bit2=c (lower right), bit3=d (bottom), bit4=e (lower left), bit5=f (upper left), bit6=g (middle). With no override active, the held digits 0 to 9 give 3F, 06, 5B, 4F, 66, 6D, 7C, 07, 7F and 67 (hex). The 6 has no top bar and the 9 has no bottom bar.
- R8: While `rst_n` is low, the held digit is 0 with no clock edge needed, so that `seg_out` shows 7'h3F unless an override is active.
- R9: `seg_out` responds to `lamp_test_n` and `blank_n` in the same cycle, with no clock edge between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the holding register samples on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears the held digit to 0 |
| digit_in | input | 4 | Digit code presented for capture |
| hold_en | input | 1 | High freezes the held digit; low lets it follow `digit_in` |
| blank_n | input | 1 | Active-low blank; forces all segments off |
| lamp_test_n | input | 1 | Active-low lamp test; forces all segments on, overriding blank |
| seg_out | output | 7 | Active-high segment drives, bit0=a through bit6=g |

## Verification
The clocked assertions assume that every input carries a known 0 or 1 at each rising edge. They also assume that `digit_in` and `hold_en` are settled before the edge on which the holding register samples them. The bench meets both assumptions: it changes inputs only on the falling clock edge and draws every random value from a fixed-seed `$urandom` stream reduced to legal bit widths. It checks the outputs on the next falling edge, so no input moves near a sampling edge.

// File: rtl/bcd7seg_pkg.sv
package bcd7seg_pkg;

  // Segment bit positions inside the seven-bit output word.
  localparam int SEG_TOP    = 0;
  localparam int SEG_UPR    = 1;
  localparam int SEG_LWR    = 2;
  localparam int SEG_BOT    = 3;
  localparam int SEG_LWL    = 4;
  localparam int SEG_UPL    = 5;
  localparam int SEG_MID    = 6;
  localparam int SEG_COUNT  = 7;

  // Largest code that is a legal decimal digit.
  localparam int LAST_DIGIT = 9;

  typedef logic [SEG_COUNT-1:0] seg_word_t;

  // What the final output stage should do with the decoded word.
  typedef enum logic [1:0] {
    OVR_PASS  = 2'b00,
    OVR_DARK  = 2'b01,
    OVR_LIGHT = 2'b10
  } ovr_mode_e;

  // Sets the bits of a word from a list of lit segments.
  function automatic seg_word_t lit(input bit t, input bit ur, input bit lr,
                                    input bit bo, input bit ll, input bit ul,
                                    input bit mi);
    seg_word_t w;
    w          = '0;
    w[SEG_TOP] = t;
    w[SEG_UPR] = ur;
    w[SEG_LWR] = lr;
    w[SEG_BOT] = bo;
    w[SEG_LWL] = ll;
    w[SEG_UPL] = ul;
    w[SEG_MID] = mi;
    return w;
  endfunction

endpackage

// File: rtl/bcd7seg_hold.sv
module bcd7seg_hold #(
  parameter int DIGIT_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DIGIT_W-1:0] digit_in,
  input  logic               hold_en,
  output logic [DIGIT_W-1:0] held_q
);

  // Transparent-low latch modelled as a clock-enabled register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
    end else if (!hold_en) begin
      held_q <= digit_in;
    end
  end

  // R1: an open latch takes the presented digit
  assert_load_open_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_en |=> held_q == $past(digit_in))
    else $error("held digit missed load");

  // R2: a closed latch keeps its content
  assert_hold_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hold_en |=> $stable(held_q))
    else $error("held digit moved while closed");

endmodule

// File: rtl/bcd7seg_decode.sv
module bcd7seg_decode
  import bcd7seg_pkg::*;
#(
  parameter int DIGIT_W = 4
) (
  input  logic [DIGIT_W-1:0] code,
  output seg_word_t          pattern
);

  localparam int CODES = 1 << DIGIT_W;

  // Decode each legal digit to its segments; other codes stay dark.
  always_comb begin
    pattern = '0;
    if (int'(code) <= LAST_DIGIT) begin
      unique case (int'(code))
        0: pattern = lit(1, 1, 1, 1, 1, 1, 0);
        1: pattern = lit(0, 1, 1, 0, 0, 0, 0);
        2: pattern = lit(1, 1, 0, 1, 1, 0, 1);
        3: pattern = lit(1, 1, 1, 1, 0, 0, 1);
        4: pattern = lit(0, 1, 1, 0, 0, 1, 1);
        5: pattern = lit(1, 0, 1, 1, 0, 1, 1);
        6: pattern = lit(0, 0, 1, 1, 1, 1, 1);
        7: pattern = lit(1, 1, 1, 0, 0, 0, 0);
        8: pattern = lit(1, 1, 1, 1, 1, 1, 1);
        9: pattern = lit(1, 1, 1, 0, 0, 1, 1);
        default: pattern = '0;
      endcase
    end
  end

  // Range sanity on the elaborated width.
  initial begin
    assert_width_fits_R7: assert (CODES > LAST_DIGIT)
      else $error("digit width too small for decimal codes");
  end

endmodule

// File: rtl/bcd7seg_override.sv
module bcd7seg_override
  import bcd7seg_pkg::*;
(
  input  seg_word_t pattern,
  input  logic      blank_n,
  input  logic      lamp_test_n,
  output seg_word_t seg_out
);

  ovr_mode_e mode;

  // Lamp test outranks blank.
  always_comb begin
    if (!lamp_test_n)  mode = OVR_LIGHT;
    else if (!blank_n) mode = OVR_DARK;
    else               mode = OVR_PASS;
  end

  // Identical per-segment output stage.
  for (genvar s = 0; s < SEG_COUNT; s++) begin : g_seg
    always_comb begin
      unique case (mode)
        OVR_LIGHT: seg_out[s] = 1'b1;
        OVR_DARK:  seg_out[s] = 1'b0;
        default:   seg_out[s] = pattern[s];
      endcase
    end
  end

endmodule

// File: rtl/bcd7seg_latch.sv
module bcd7seg_latch
  import bcd7seg_pkg::*;
#(
  parameter int DIGIT_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DIGIT_W-1:0] digit_in,
  input  logic               hold_en,
  input  logic               blank_n,
  input  logic               lamp_test_n,
  output logic [6:0]         seg_out
);

  logic [DIGIT_W-1:0] held_q;
  seg_word_t          pattern;
  seg_word_t          seg_w;

  bcd7seg_hold #(.DIGIT_W(DIGIT_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .digit_in (digit_in),
    .hold_en  (hold_en),
    .held_q   (held_q)
  );

  bcd7seg_decode #(.DIGIT_W(DIGIT_W)) u_decode (
    .code    (held_q),
    .pattern (pattern)
  );

  bcd7seg_override u_ovr (
    .pattern     (pattern),
    .blank_n     (blank_n),
    .lamp_test_n (lamp_test_n),
    .seg_out     (seg_w)
  );

  assign seg_out = seg_w;

  // R3: lamp test lights everything
  assert_lamp_all_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !lamp_test_n |-> seg_out == 7'h7F)
    else $error("lamp test did not light all segments");

  // R4: blank darkens everything when lamp test is idle
  assert_blank_all_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lamp_test_n && !blank_n) |-> seg_out == 7'h00)
    else $error("blank left a segment lit");

  // R6: non-decimal held codes stay dark
  assert_illegal_dark_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(held_q) > LAST_DIGIT && lamp_test_n && blank_n) |-> seg_out == 7'h00)
    else $error("illegal code lit a segment");

  // R5: releasing overrides with the latch closed restores the decoded digit
  assert_release_shows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_en && lamp_test_n && blank_n && !($past(lamp_test_n) && $past(blank_n)))
      |-> seg_out == pattern)
    else $error("held digit not restored after override");

endmodule

// File: tb/bcd7seg_latch_tb.sv
module bcd7seg_latch_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] digit_in;
  logic       hold_en;
  logic       blank_n;
  logic       lamp_test_n;
  logic [6:0] seg_out;

  int vectors = 0;
  int fails   = 0;
  int model_q = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  bcd7seg_latch u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .digit_in    (digit_in),
    .hold_en     (hold_en),
    .blank_n     (blank_n),
    .lamp_test_n (lamp_test_n),
    .seg_out     (seg_out)
  );

  // Reference shapes, bit0=a ... bit6=g (R7), dark above nine (R6).
  function automatic logic [6:0] ref_shape(input int code);
    case (code)
      0: return 7'h3F;
      1: return 7'h06;
      2: return 7'h5B;
      3: return 7'h4F;
      4: return 7'h66;
      5: return 7'h6D;
      6: return 7'h7C;
      7: return 7'h07;
      8: return 7'h7F;
      9: return 7'h67;
      default: return 7'h00;
    endcase
  endfunction

  function automatic logic [6:0] ref_out(input int code, input logic bl, input logic lt);
    if (!lt) return 7'h7F;
    if (!bl) return 7'h00;
    return ref_shape(code);
  endfunction

  task automatic check(input string req, input logic [6:0] exp);
    vectors++;
    if (seg_out !== exp) begin
      fails++;
      $display("FAIL %s: seg_out=%h expected=%h (held model %0d)", req, seg_out, exp, model_q);
    end
  endtask

  // Drive on falling edge, clock once, check on next falling edge.
  task automatic step(input logic [3:0] d, input logic he, input logic bl,
                      input logic lt, input string req);
    digit_in = d; hold_en = he; blank_n = bl; lamp_test_n = lt;
    @(posedge clk);
    if (!he) model_q = int'(d);
    @(negedge clk);
    check(req, ref_out(model_q, bl, lt));
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; digit_in = 4'd7; hold_en = 1'b0; blank_n = 1'b1; lamp_test_n = 1'b1;
    #1;
    model_q = 0;
    check("R8 async reset shows 0", 7'h3F);
    @(negedge clk); @(negedge clk);
    check("R8 reset holds 0", 7'h3F);
    rst_n = 1'b1;

    // R7/R6/R3/R4: every code under every override combination
    for (int c = 0; c < 16; c++) begin
      for (int k = 0; k < 4; k++) begin
        step(4'(c), 1'b0, k[0], k[1], (c > 9) ? "R6 dark code" : "R7 pattern / R3 R4 override");
      end
    end

    // R2: digit_in ignored while held
    step(4'd2, 1'b0, 1'b1, 1'b1, "R1 load 2");
    for (int c = 0; c < 16; c++) step(4'(c), 1'b1, 1'b1, 1'b1, "R2 held ignores input");

    // R9: overrides act without a clock edge
    lamp_test_n = 1'b0; #1; check("R9 lamp immediate", 7'h7F);
    lamp_test_n = 1'b1; blank_n = 1'b0; #1; check("R9 blank immediate", 7'h00);
    blank_n = 1'b1; #1; check("R9 release immediate", 7'h5B);
    @(negedge clk);

    // R5: overrides during hold do not disturb digit
    step(4'd9, 1'b0, 1'b1, 1'b1, "R1 load 9");
    step(4'd1, 1'b1, 1'b1, 1'b0, "R3 lamp while held");
    step(4'd4, 1'b1, 1'b0, 1'b1, "R4 blank while held");
    step(4'd5, 1'b1, 1'b0, 1'b0, "R3 lamp beats blank");
    step(4'd0, 1'b1, 1'b1, 1'b1, "R5 release shows 9");
    step(4'd6, 1'b0, 1'b0, 1'b1, "R1 load under blank");
    step(4'd6, 1'b1, 1'b1, 1'b1, "R5 release shows 6");

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] d;
      logic he, bl, lt;
      d  = 4'($urandom);
      he = ($urandom % 3) == 0;
      bl = ($urandom % 5) != 0;
      lt = ($urandom % 7) != 0;
      step(d, he, bl, lt, "R1 R2 R5 random");
    end

    // R8: reset mid-run
    step(4'd8, 1'b0, 1'b1, 1'b1, "R1 load 8");
    rst_n = 1'b0; #1; model_q = 0;
    check("R8 async clear", 7'h3F);
    @(negedge clk);
    rst_n = 1'b1;
    step(4'd3, 1'b0, 1'b1, 1'b1, "R1 load after reset");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule